// File: doc/BRIEF.md
# Register-Controlled PWM Timer Channel

This block produces one active-high pulse-width-modulated output from two small registers reached through a plain write strobe and an address-decoded read-back bus. A control word holds the run enable, a spare select bit, an update-hold bit and a power-of-two clock division. A count word holds the period length and the high-phase length, both counted in prescaled clock ticks. The division exponent is built from two fields: a 4-bit coarse field that counts in steps of two and a half-step bit that adds one. The resulting exponent is capped at 24.

Every write lands in shadow copies at once. The running waveform takes a new period, phase and division only at the end of a period, and all three change together. While the hold bit is set, nothing is transferred. A setting with a zero period or a zero phase is refused: the channel does not start, and a running channel keeps its last legal set. The register port has no back-pressure. A write is accepted on every clock edge that sees the strobe high, and read data is a combinational function of the address.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset both registers read zero and `pwm_out` is low.
- R2: The control word at byte address 0x0 keeps bit 0 (enable), bit 4 (select), bit 11 (hold), bit 15 (half-step) and bits 19:16 (coarse division). The count word at 0x4 keeps the period in bits 25:16 and the phase in bits 9:0. Read-back returns the shadow values, and every other bit reads 0. Any other address reads 0 and ignores writes.
- R3: Once running, the output is high for `phase` ticks and low for the rest of a `period`-tick cycle. The first high appears in the clock cycle after the write that made the channel eligible to start.
- R4: Each tick lasts 2^d clocks, where d = min(2*coarse + half, 24).
- R5: The channel does not start while the shadow period or phase is zero or while hold is set. It starts as soon as enable is set, hold is clear and both fields are nonzero.
- R6: While hold is 1, writes change only the shadow copies. The pending set is applied at the first period boundary whose closing edge already sees hold at 0.
- R7: While running, the active period, phase and division change only at a period boundary, and a set containing a zero field is never applied.
- R8: Clearing enable drives the output low in the next cycle and resets the counter and prescaler. Enabling again starts a fresh period, beginning high.
- R9: A phase greater than or equal to the period gives a constantly high output.
- R10: A running channel is always high in the first tick of every period, so the duty cycle is never 0%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 1 | PWM output, active high |

## Verification
Two events can meet on one clock edge: the write that clears hold, and the period boundary that would transfer the shadow set. The bench times the hold-clearing write so that it lands exactly on a boundary edge. That edge must not load the pending set, because the hold value present before the edge is still 1. The new period and phase must first appear after the following boundary. A scoreboard of per-cycle output levels, computed from the requirement formulas, detects a transfer that comes one period early or late, or a transfer that mixes old and new fields.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 10;
  localparam int DIVF_W  = 4;
  localparam int EXP_W   = DIVF_W + 1;
  localparam int MAX_EXP = 24;

  localparam int OFF_CTRL = 0;
  localparam int OFF_CNT  = 4;

  // control word bit positions
  localparam int B_EN     = 0;
  localparam int B_SEL    = 4;
  localparam int B_HOLD   = 11;
  localparam int B_HALF   = 15;
  localparam int B_DIV_LO = 16;
  // count word bit positions
  localparam int B_PH_LO  = 0;
  localparam int B_PER_LO = 16;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] phase;
    logic [EXP_W-1:0] expo;
  } tcfg_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              hold,
  output tcfg_t             shadow
);
  logic              en_q, sel_q, hold_q, half_q;
  logic [DIVF_W-1:0] divf_q;
  logic [CNT_W-1:0]  per_q, ph_q;
  logic              hit_ctrl, hit_cnt;
  logic [EXP_W:0]    raw_exp;

  assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign hit_cnt  = (addr == ADDR_W'(OFF_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      hold_q <= 1'b0;
      half_q <= 1'b0;
      divf_q <= '0;
      per_q  <= '0;
      ph_q   <= '0;
    end else if (wr) begin
      if (hit_ctrl) begin
        en_q   <= wdata[B_EN];
        sel_q  <= wdata[B_SEL];
        hold_q <= wdata[B_HOLD];
        half_q <= wdata[B_HALF];
        divf_q <= wdata[B_DIV_LO +: DIVF_W];
      end
      if (hit_cnt) begin
        per_q <= wdata[B_PER_LO +: CNT_W];
        ph_q  <= wdata[B_PH_LO +: CNT_W];
      end
    end
  end

  // exponent = 2*coarse + half, capped
  assign raw_exp = {1'b0, divf_q, half_q};

  always_comb begin
    shadow.period = per_q;
    shadow.phase  = ph_q;
    if (raw_exp > (EXP_W+1)'(MAX_EXP)) shadow.expo = EXP_W'(MAX_EXP);
    else                               shadow.expo = raw_exp[EXP_W-1:0];
  end

  assign en   = en_q;
  assign hold = hold_q;

  always_comb begin
    rdata = '0;
    if (hit_ctrl) begin
      rdata[B_EN]                 = en_q;
      rdata[B_SEL]                = sel_q;
      rdata[B_HOLD]               = hold_q;
      rdata[B_HALF]               = half_q;
      rdata[B_DIV_LO +: DIVF_W]   = divf_q;
    end else if (hit_cnt) begin
      rdata[B_PER_LO +: CNT_W]    = per_q;
      rdata[B_PH_LO +: CNT_W]     = ph_q;
    end
  end
endmodule

// File: rtl/pwm_timer_prescale.sv
module pwm_timer_prescale #(
  parameter int EXP_W   = 5,
  parameter int MAX_EXP = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  logic [MAX_EXP-1:0] pre_q;
  logic [MAX_EXP-1:0] mask;

  // mask has the low 'expo' bits set
  for (genvar i = 0; i < MAX_EXP; i++) begin : g_mask
    assign mask[i] = (EXP_W'(i) < expo);
  end

  assign tick = run && (pre_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_q <= '0;
    else if (!run || tick)  pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_timer_wave.sv
module pwm_timer_wave #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = (cnt_q == period - 1'b1);
  assign boundary = tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (boundary) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
  assign pwm = run && en && (cnt_q < phase);
endmodule

// File: rtl/pwm_timer_ctl.sv
module pwm_timer_ctl
  import pwm_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  hold,
  input  tcfg_t shadow,
  input  logic  boundary,
  output logic  run,
  output tcfg_t active
);
  logic run_q, legal, start, load;

  assign legal = (shadow.period != '0) && (shadow.phase != '0);
  assign start = en && !run_q && !hold && legal;
  assign load  = !hold && legal && (!run_q || boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      active <= '0;
    end else begin
      run_q <= start || (run_q && en);
      if (load) active <= shadow;
    end
  end

  assign run = run_q;
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  logic             en_w, hold_w, run_w, tick_w, bnd_w;
  tcfg_t            sh_cfg, act_cfg;
  logic [CNT_W-1:0] cnt_w;

  pwm_timer_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .en(en_w), .hold(hold_w), .shadow(sh_cfg)
  );

  pwm_timer_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .hold(hold_w),
    .shadow(sh_cfg), .boundary(bnd_w), .run(run_w), .active(act_cfg)
  );

  pwm_timer_prescale #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .expo(act_cfg.expo), .tick(tick_w)
  );

  pwm_timer_wave #(.CNT_W(CNT_W)) wave_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .en(en_w), .tick(tick_w),
    .period(act_cfg.period), .phase(act_cfg.phase),
    .cnt(cnt_w), .boundary(bnd_w), .pwm(pwm_out)
  );
endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk
  import pwm_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             hold,
  input logic             run,
  input logic             boundary,
  input logic [CNT_W-1:0] cnt,
  input tcfg_t            shadow,
  input tcfg_t            active,
  input logic             pwm_out
);
  a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  a_r5_start_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(shadow.period != '0 && shadow.phase != '0 && !hold));

  a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(active));

  a_r7_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(active)) |-> $past(boundary));

  a_r7_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (active.period != '0 && active.phase != '0));

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < active.period));

  a_r10_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && cnt == '0) |-> pwm_out);
endmodule

bind pwm_timer_chan pwm_timer_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_w), .hold(hold_w), .run(run_w),
  .boundary(bnd_w), .cnt(cnt_w), .shadow(sh_cfg), .active(act_cfg),
  .pwm_out(pwm_out)
);

// File: tb/pwm_timer_chan_tb_top.sv
module pwm_timer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int total = 0;
  int bad = 0;
  bit exp_q[$];
  string cur_req = "R1";

  always #5 clk = ~clk;

  pwm_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: one expected output level per cycle, sampled at negedge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(cur_req, {31'b0, pwm_out}, {31'b0, e});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] expv);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, bus_rdata, expv);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
  endtask

  function automatic bit wave_bit(input int j, input int p, input int ph, input int d);
    int c;
    c = (j >> d) % p;
    return (c < ph);
  endfunction

  // index 0 is the cycle of the enabling write edge, output still low
  task automatic push_wave(input int n, input int p, input int ph, input int d);
    exp_q.push_back(1'b0);
    for (int j = 0; j < n; j++) exp_q.push_back(wave_bit(j, p, ph, d));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1", 4'h0, 32'h0);
    rd_chk("R1", 4'h4, 32'h0);
    chk("R1", {31'b0, pwm_out}, 32'h0);

    // R2 mask, R5 guard with hold set and zero counts
    wr(4'h0, 32'hFFFF_FFFF);
    cur_req = "R5";
    push_zeros(8);
    drain();
    rd_chk("R2", 4'h0, 32'h000F_8811);

    wr(4'h0, 32'h0000_0001);
    cur_req = "R5";
    push_zeros(6);
    drain();
    wr(4'h8, 32'hFFFF_FFFF);
    rd_chk("R2", 4'h8, 32'h0);
    rd_chk("R2", 4'h0, 32'h0000_0001);
    wr(4'h4, 32'h0005_0000);
    cur_req = "R5";
    push_zeros(6);
    drain();

    // R5 release and R3 waveform: period 5, phase 2, no division
    wr(4'h4, 32'h0005_0002);
    cur_req = "R3";
    push_wave(20, 5, 2, 0);
    drain();
    rd_chk("R2", 4'h4, 32'h0005_0002);
    wr(4'hC, 32'hFFFF_FFFF);
    rd_chk("R2", 4'h4, 32'h0005_0002);

    // R8 disable
    wr(4'h0, 32'h0);
    cur_req = "R8";
    push_zeros(6);
    drain();

    // R4 division: coarse 1 + half 1 -> d=3; R10 phase of one tick
    wr(4'h4, 32'h0003_0001);
    cur_req = "R8";
    push_zeros(3);
    drain();
    wr(4'h0, 32'h0001_8001);
    cur_req = "R4 R10";
    push_wave(80, 3, 1, 3);
    drain();
    rd_chk("R2", 4'h0, 32'h0001_8001);

    // R9 phase above period, R8 re-enable starts high
    wr(4'h0, 32'h0);
    cur_req = "R8";
    push_zeros(3);
    drain();
    wr(4'h4, 32'h0003_0007);
    wr(4'h0, 32'h0000_0001);
    cur_req = "R9";
    push_wave(12, 3, 7, 0);
    drain();

    // R6/R7 hold release coinciding with a boundary edge
    wr(4'h0, 32'h0);
    drain();
    wr(4'h4, 32'h0004_0001);
    wr(4'h0, 32'h0000_0001);          // edge e0, run from e1
    cur_req = "R6/R7";
    exp_q.push_back(1'b0);
    for (int k = 1; k <= 12; k++) exp_q.push_back(((k - 1) % 4) < 1);
    for (int k = 13; k <= 30; k++) exp_q.push_back(((k - 13) % 6) < 3);
    wr(4'h0, 32'h0000_0801);          // e1 hold on
    wr(4'h4, 32'h0006_0003);          // e2 shadow only
    idle(6);                           // e3..e8
    wr(4'h0, 32'h0000_0001);          // e9 hold off, on a boundary edge
    drain();
    rd_chk("R6", 4'h4, 32'h0006_0003);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule